// File: doc/BRIEF.md
# PLL Bypass and Relock Controller

This block parks a group of PLLs in low-power bypass and later returns each one to the mode it had before. For every PLL it can read the live clock-mode word, write a new clock-mode word, and read a one-bit idle-status flag. A bypass command first copies the PLL's whole clock-mode word into a private slot. It then writes the word back with only the three-bit mode field changed to the bypass code. The block waits until the idle flag drops before it reports completion.

A restore command writes the saved word back unchanged. If the saved mode field is the lock code, the controller also waits for the idle flag to rise, which shows that the PLL is out of bypass. A clear command sets every saved slot to zero. A separate combinational path reports the post-divider field of any PLL, taken from that PLL's clock-select word.

Commands run one at a time. A command is accepted only while the controller is idle. `busy` is high while a command is in flight, and `done` pulses once at its end, qualifying the `err_idx` and `timeout` flags.

Top module: `pll_bypass_ctrl`

## Requirements
- R1: A bypass command on PLL i saves PLL i's full clock-mode word and makes exactly one write to PLL i. The write carries bits [2:0] = 5 (bypass code) and every other bit equal to the saved word.
- R2: After the bypass write, `done` is held off until idle-status bit i reads 0. When the flag is already 0, `done` is visible two clock edges after the accepting edge.
- R3: A restore command on PLL i makes exactly one write to PLL i, carrying the saved word unchanged.
- R4: When the saved word's bits [2:0] equal 7 (lock code), restore waits for idle-status bit i to read 1. For any other mode value, `done` follows one edge after the accepting edge, whatever the idle flag reads.
- R5: A clear command (op code 3) sets every saved word to zero. It completes with `done` on the accepting edge, so a later restore writes zero.
- R6: `div_out` equals bits [7:0] of the clock-select word of the PLL chosen by `div_idx`, with no shift applied. It reads 0 when `div_idx` is not below NUM_PLL.
- R7: A bypass (op 1) or restore (op 2) with `cmd_idx` not below NUM_PLL sets `err_idx`, makes no write, and signals `done` on the accepting edge.
- R8: `busy` is high from the accepting edge until `done` has pulsed. `done` lasts one cycle. Commands presented while busy, and op code 0, are ignored.
- R9: A wait still unmet after TIMEOUT cycles ends the command with `timeout` set, `done` appearing TIMEOUT+1 edges after the accepting edge.
- R10: After reset, `busy`, `done`, `err_idx`, `timeout` and all write enables are low, and all saved words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 1 bypass, 2 restore, 3 clear, 0 none |
| cmd_idx | input | IDX_W | PLL index for bypass or restore |
| mode_rd | input | NUM_PLL*WORD_W | Live clock-mode words, PLL 0 in the low slice |
| idle_st | input | NUM_PLL | Idle-status flag per PLL |
| mode_wr_en | output | NUM_PLL | One-hot write strobe to the clock-mode registers |
| mode_wr_data | output | WORD_W | Clock-mode word being written |
| clksel | input | NUM_PLL*WORD_W | Clock-select words, PLL 0 in the low slice |
| div_idx | input | IDX_W | PLL whose post-divider is reported |
| div_out | output | 8 | Post-divider field |
| busy | output | 1 | Command in flight |
| done | output | 1 | One-cycle completion pulse |
| err_idx | output | 1 | Last command had an out-of-range index |
| timeout | output | 1 | Last command's wait expired |

## Verification
The bench builds the block with NUM_PLL = 3, WORD_W = 16 and TIMEOUT = 8. With three PLLs the two-bit index can name a fourth, nonexistent PLL, which reaches the out-of-range rejection path. The short limit makes a stuck idle flag expire within nine edges, so the exact timeout latency can be checked. The 16-bit word keeps upper bits beside the mode field, showing that bypass and restore carry them through untouched.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_BYPASS  = 2'd1,
    OP_RESTORE = 2'd2,
    OP_CLEAR   = 2'd3
  } pbc_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_WAIT,
    ST_DONE
  } pbc_state_e;

  localparam logic [2:0] MODE_BYPASS = 3'd5;
  localparam logic [2:0] MODE_LOCK   = 3'd7;

  function automatic logic wants_lock_wait(input logic [2:0] mode_field);
    return mode_field == MODE_LOCK;
  endfunction
endpackage

// File: rtl/pbc_save_bank.sv
module pbc_save_bank #(
  parameter int NUM_PLL = 3,
  parameter int WORD_W  = 32,
  parameter int IDX_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_all,
  input  logic                      sv_en,
  input  logic [IDX_W-1:0]          sv_idx,
  input  logic [WORD_W-1:0]         sv_data,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic [WORD_W-1:0]         rd_data
);
  logic [WORD_W-1:0] slot [NUM_PLL];

  for (genvar g = 0; g < NUM_PLL; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n || clr_all) slot[g] <= '0;
      else if (sv_en && sv_idx == IDX_W'(g)) slot[g] <= sv_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_PLL; i++)
      if (rd_idx == IDX_W'(i)) rd_data = slot[i];
  end
endmodule

// File: rtl/pbc_wait_timer.sv
module pbc_wait_timer #(
  parameter int TIMEOUT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (!expire)   cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == CNT_W'(TIMEOUT - 1));
endmodule

// File: rtl/pbc_div_mux.sv
module pbc_div_mux #(
  parameter int NUM_PLL = 3,
  parameter int WORD_W  = 32,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_PLL*WORD_W-1:0] clksel,
  input  logic [IDX_W-1:0]          sel,
  output logic [7:0]                div
);
  function automatic logic [7:0] post_div(input logic [WORD_W-1:0] w);
    return w[7:0];
  endfunction

  always_comb begin
    div = '0;
    for (int i = 0; i < NUM_PLL; i++)
      if (sel == IDX_W'(i)) div = post_div(clksel[i*WORD_W +: WORD_W]);
  end
endmodule

// File: rtl/pll_bypass_ctrl.sv
module pll_bypass_ctrl #(
  parameter int NUM_PLL = 3,
  parameter int WORD_W  = 32,
  parameter int TIMEOUT = 4096,
  localparam int IDX_W  = $clog2(NUM_PLL + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [1:0]                cmd_op,
  input  logic [IDX_W-1:0]          cmd_idx,
  input  logic [NUM_PLL*WORD_W-1:0] mode_rd,
  input  logic [NUM_PLL-1:0]        idle_st,
  output logic [NUM_PLL-1:0]        mode_wr_en,
  output logic [WORD_W-1:0]         mode_wr_data,
  input  logic [NUM_PLL*WORD_W-1:0] clksel,
  input  logic [IDX_W-1:0]          div_idx,
  output logic [7:0]                div_out,
  output logic                      busy,
  output logic                      done,
  output logic                      err_idx,
  output logic                      timeout
);
  import pbc_pkg::*;

  function automatic logic [WORD_W-1:0] bypass_word(input logic [WORD_W-1:0] w);
    return {w[WORD_W-1:3], MODE_BYPASS};
  endfunction

  pbc_state_e        state;
  pbc_op_e           cur_op;
  logic [IDX_W-1:0]  cur_idx;
  logic [WORD_W-1:0] saved_word;
  logic [WORD_W-1:0] live_word;
  logic              accept;
  logic              idx_ok;
  logic              wait_idle_bit;
  logic              wait_met;
  logic              wait_expire;
  logic              wr_is_bypass;
  logic              save_evt;
  logic              clear_evt;

  assign accept    = cmd_valid && state == ST_IDLE && pbc_op_e'(cmd_op) != OP_NONE;
  assign idx_ok    = cmd_idx < IDX_W'(NUM_PLL);
  assign clear_evt = accept && pbc_op_e'(cmd_op) == OP_CLEAR;
  assign save_evt  = accept && pbc_op_e'(cmd_op) == OP_BYPASS && idx_ok;

  always_comb begin
    live_word     = '0;
    wait_idle_bit = 1'b0;
    for (int i = 0; i < NUM_PLL; i++) begin
      if (cmd_idx == IDX_W'(i)) live_word = mode_rd[i*WORD_W +: WORD_W];
      if (cur_idx == IDX_W'(i)) wait_idle_bit = idle_st[i];
    end
  end

  pbc_save_bank #(.NUM_PLL(NUM_PLL), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_all (clear_evt),
    .sv_en   (save_evt),
    .sv_idx  (cmd_idx),
    .sv_data (live_word),
    .rd_idx  (cur_idx),
    .rd_data (saved_word)
  );

  pbc_wait_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (state == ST_WAIT && !wait_met),
    .expire (wait_expire)
  );

  pbc_div_mux #(.NUM_PLL(NUM_PLL), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_div (
    .clksel (clksel),
    .sel    (div_idx),
    .div    (div_out)
  );

  assign wr_is_bypass = cur_op == OP_BYPASS;
  assign wait_met     = wr_is_bypass ? !wait_idle_bit : wait_idle_bit;

  always_comb begin
    mode_wr_en   = '0;
    mode_wr_data = wr_is_bypass ? bypass_word(saved_word) : saved_word;
    if (state == ST_WRITE)
      for (int i = 0; i < NUM_PLL; i++)
        mode_wr_en[i] = cur_idx == IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cur_op  <= OP_NONE;
      cur_idx <= '0;
      err_idx <= 1'b0;
      timeout <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          cur_op  <= pbc_op_e'(cmd_op);
          cur_idx <= cmd_idx;
          timeout <= 1'b0;
          err_idx <= 1'b0;
          if (pbc_op_e'(cmd_op) == OP_CLEAR) state <= ST_DONE;
          else if (!idx_ok) begin
            err_idx <= 1'b1;
            state   <= ST_DONE;
          end else state <= ST_WRITE;
        end
        ST_WRITE: begin
          if (wr_is_bypass || wants_lock_wait(saved_word[2:0])) state <= ST_WAIT;
          else state <= ST_DONE;
        end
        ST_WAIT: begin
          if (wait_met) state <= ST_DONE;
          else if (wait_expire) begin
            timeout <= 1'b1;
            state   <= ST_DONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = state != ST_IDLE;
  assign done = state == ST_DONE;
endmodule

// File: rtl/pbc_checker.sv
module pbc_checker #(
  parameter int NUM_PLL = 3,
  parameter int WORD_W  = 32,
  parameter int IDX_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               done,
  input logic               err_idx,
  input logic               timeout,
  input logic [NUM_PLL-1:0] mode_wr_en,
  input logic [WORD_W-1:0]  mode_wr_data,
  input logic               wr_is_bypass,
  input logic               wait_idle_bit,
  input logic [IDX_W-1:0]   cur_idx
);
  // R1: a bypass write always carries the bypass code
  a_r1_bypass_code: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr_en != '0 && wr_is_bypass) |-> mode_wr_data[2:0] == 3'd5);

  // R1, R3: never more than one PLL written at once
  a_r1_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mode_wr_en));

  // R1: one write per command
  a_r1_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr_en != '0) |=> mode_wr_en == '0);

  // R2: a bypass ends without timeout only after the idle flag read 0
  a_r2_idle_seen: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && wr_is_bypass && !timeout && !err_idx) |-> !$past(wait_idle_bit));

  // R7: a rejected index makes no write
  a_r7_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_idx) |-> $past(mode_wr_en) == '0);

  // R8: done lasts one cycle and only while busy
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r8_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> mode_wr_en == '0);

  // R8: target index held during a command
  a_r8_idx_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(done)) |-> $stable(cur_idx));
endmodule

bind pll_bypass_ctrl pbc_checker #(.NUM_PLL(NUM_PLL), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_pbc_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .done          (done),
  .err_idx       (err_idx),
  .timeout       (timeout),
  .mode_wr_en    (mode_wr_en),
  .mode_wr_data  (mode_wr_data),
  .wr_is_bypass  (wr_is_bypass),
  .wait_idle_bit (wait_idle_bit),
  .cur_idx       (cur_idx)
);

// File: tb/pll_bypass_ctrl_test.sv
`timescale 1ns/1ps
module pll_bypass_ctrl_test;
  localparam int NP = 3;
  localparam int WW = 16;
  localparam int TO = 8;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [IW-1:0] cmd_idx = '0;
  logic [NP*WW-1:0] mode_rd;
  logic [NP-1:0] idle_st = '0;
  logic [NP-1:0] mode_wr_en;
  logic [WW-1:0] mode_wr_data;
  logic [NP*WW-1:0] clksel = '0;
  logic [IW-1:0] div_idx = '0;
  logic [7:0] div_out;
  logic busy, done, err_idx, timeout;

  int n_cmp = 0;
  int n_bad = 0;
  int lat;

  logic [WW-1:0] pll_mode [NP];
  int wr_cnt [NP];
  logic pre_en = 1'b0;
  int pre_idx = 0;
  logic [WW-1:0] pre_val = '0;

  always #4 clk = ~clk;

  pll_bypass_ctrl #(.NUM_PLL(NP), .WORD_W(WW), .TIMEOUT(TO)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
    .mode_rd(mode_rd), .idle_st(idle_st), .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
    .clksel(clksel), .div_idx(div_idx), .div_out(div_out), .busy(busy), .done(done),
    .err_idx(err_idx), .timeout(timeout));

  // PLL register model
  always @(posedge clk) begin
    for (int i = 0; i < NP; i++) begin
      if (pre_en && pre_idx == i) pll_mode[i] <= pre_val;
      else if (mode_wr_en[i]) begin
        pll_mode[i] <= mode_wr_data;
        wr_cnt[i] <= wr_cnt[i] + 1;
      end
    end
  end
  assign mode_rd = {pll_mode[2], pll_mode[1], pll_mode[0]};

  task automatic check(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic preset(input int idx, input logic [WW-1:0] val);
    @(negedge clk);
    pre_en = 1'b1; pre_idx = idx; pre_val = val;
    @(negedge clk);
    pre_en = 1'b0;
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [IW-1:0] idx);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd0;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check("R8 done seen", done, 1);
    check("R8 busy with done", busy, 1);
    @(negedge clk);
    check("R8 done one cycle", done, 0);
    check("R8 busy released", busy, 0);
  endtask

  task automatic t_reset();
    check("R10 busy", busy, 0);
    check("R10 done", done, 0);
    check("R10 err", err_idx, 0);
    check("R10 timeout", timeout, 0);
    check("R10 wr_en", mode_wr_en, 0);
  endtask

  task automatic t_bypass();
    int c1, c2;
    preset(1, 16'h1237);
    preset(2, 16'h00A4);
    idle_st = 3'b010;
    c1 = wr_cnt[1];
    fork begin repeat (6) @(negedge clk); idle_st[1] = 1'b0; end join_none
    run_cmd(2'd1, 2'd1);
    check("R1 bypass word", pll_mode[1], 16'h1235);
    check("R1 one write", wr_cnt[1] - c1, 1);
    check("R2 waited for idle 0", lat >= 3, 1);
    check("R2 no timeout", timeout, 0);
    c2 = wr_cnt[2];
    run_cmd(2'd1, 2'd2);
    check("R2 immediate latency", lat, 2);
    check("R1 bypass word pll2", pll_mode[2], 16'h00A5);
    check("R1 one write pll2", wr_cnt[2] - c2, 1);
  endtask

  task automatic t_restore();
    int c1;
    idle_st = 3'b000;
    c1 = wr_cnt[1];
    fork begin repeat (5) @(negedge clk); idle_st[1] = 1'b1; end join_none
    run_cmd(2'd2, 2'd1);
    check("R3 restored word", pll_mode[1], 16'h1237);
    check("R3 one write", wr_cnt[1] - c1, 1);
    check("R4 lock waited", lat >= 3, 1);
    check("R4 no timeout", timeout, 0);
    idle_st[2] = 1'b0;
    run_cmd(2'd2, 2'd2);
    check("R3 restored pll2", pll_mode[2], 16'h00A4);
    check("R4 non-lock latency", lat, 1);
    check("R4 non-lock no timeout", timeout, 0);
  endtask

  task automatic t_timeout();
    int c2;
    preset(0, 16'hC0C7);
    idle_st[0] = 1'b1;
    c2 = wr_cnt[2];
    fork begin
      repeat (4) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'd2; cmd_idx = 2'd2;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'd0;
    end join_none
    run_cmd(2'd1, 2'd0);
    check("R9 timeout flag", timeout, 1);
    check("R9 timeout latency", lat, TO + 1);
    check("R9 bypass still written", pll_mode[0], 16'hC0C5);
    check("R8 busy command ignored", wr_cnt[2] - c2, 0);
    idle_st[0] = 1'b0;
  endtask

  task automatic t_err();
    int tot;
    tot = wr_cnt[0] + wr_cnt[1] + wr_cnt[2];
    run_cmd(2'd1, 2'd3);
    check("R7 err flag", err_idx, 1);
    check("R7 latency", lat, 0);
    check("R7 no write", wr_cnt[0] + wr_cnt[1] + wr_cnt[2] - tot, 0);
    run_cmd(2'd2, 2'd3);
    check("R7 err restore", err_idx, 1);
    check("R7 no write restore", wr_cnt[0] + wr_cnt[1] + wr_cnt[2] - tot, 0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_idx = 2'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R8 op0 ignored", busy, 0);
    check("R8 op0 no write", wr_cnt[0] + wr_cnt[1] + wr_cnt[2] - tot, 0);
  endtask

  task automatic t_clear();
    int c1;
    run_cmd(2'd3, 2'd0);
    check("R5 clear latency", lat, 0);
    check("R5 clear no err", err_idx, 0);
    preset(1, 16'hBEEF);
    c1 = wr_cnt[1];
    run_cmd(2'd2, 2'd1);
    check("R5 restore after clear", pll_mode[1], 16'h0000);
    check("R5 write made", wr_cnt[1] - c1, 1);
    check("R4 zero mode no wait", lat, 1);
  endtask

  task automatic t_div();
    clksel = {16'h33F0, 16'h1201, 16'hAB5C};
    div_idx = 2'd0; #1; check("R6 div pll0", div_out, 8'h5C);
    div_idx = 2'd1; #1; check("R6 div pll1", div_out, 8'h01);
    div_idx = 2'd2; #1; check("R6 div pll2", div_out, 8'hF0);
    div_idx = 2'd3; #1; check("R6 div out of range", div_out, 8'h00);
  endtask

  initial begin
    for (int i = 0; i < NP; i++) begin
      pll_mode[i] = '0;
      wr_cnt[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_restore();
    t_timeout();
    t_err();
    t_clear();
    t_div();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule